// File: doc/BRIEF.md
# AHB-Lite to APB4 Bridge

This block sits on an AHB-Lite bus as a slave. It turns each transfer it accepts into exactly one APB4 access on the peripheral side. The bridge holds one request at a time, so no address pipelining crosses it. While the request is in flight, the bridge holds the AHB data phase by pulling its ready output low. When the APB access ends, it returns the read data, or an error, in the AHB form.

The APB side runs a SETUP cycle and then one or more ACCESS cycles. For writes, byte strobes are derived from the transfer size and the low address bits. A watchdog counts ACCESS cycles. If the peripheral never answers, the watchdog abandons the access and reports an error, so a hung slave cannot freeze the whole bus.

Top module: `lite_apb_bridge`

## Requirements
- R1: A transfer is accepted only in a cycle where ahbSel is high, ahbTrans[1] is high (NONSEQ 2'b10 or SEQ 2'b11) and ahbReadyIn is high. IDLE (2'b00) and BUSY (2'b01) cycles, unselected cycles and cycles with ahbReadyIn low start no APB access.
- R2: While no request is held, ahbReadyOut is 1 and ahbResp is OKAY (2'b00). This is also the state after reset, with apbSel and apbEnable both 0.
- R3: Only one request is held at a time. ahbReadyOut stays 0 from the cycle after acceptance until the APB access has ended, and it is never 1 while apbSel is 1.
- R4: Every APB access is one cycle with apbSel=1 and apbEnable=0, followed by cycles with apbSel=1 and apbEnable=1 until apbReady=1. apbAddr and apbWdata stay stable across the ACCESS cycles.
- R5: For a write, apbStrb bit i is set when lane i lies in the naturally aligned block of 2^ahbSize bytes containing the address. Byte at offset 1 gives 4'b0010, halfword at offset 2 gives 4'b1100, and word gives 4'b1111. For every read, apbStrb is 4'b0000.
- R6: The write data is taken from ahbWdata in the first data-phase cycle, the cycle after acceptance. Later changes of ahbWdata have no effect on the written value.
- R7: A read that the peripheral completes with apbReady=1 and apbSlvErr=0 ends with ahbReadyOut=1, ahbResp=OKAY and ahbRdata equal to the peripheral's read data, in the cycle after apbReady.
- R8: An access that ends with apbSlvErr=1 is answered with two cycles of ahbResp=ERROR (2'b01). In the first cycle ahbReadyOut is 0, and in the second it is 1.
- R9: If apbReady stays 0 for TIMEOUT ACCESS cycles, the bridge drops apbSel and answers with the same two-cycle ERROR response as R8.
- R10: A zero-wait access keeps ahbReadyOut low for exactly 3 cycles, and each APB wait state adds one cycle. An apbReady arriving in the last ACCESS cycle of the watchdog window completes normally and is not treated as a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ahbSel | input | 1 | Slave select from the address decoder |
| ahbAddr | input | ADDR_W | Address-phase address |
| ahbTrans | input | 2 | Transfer type |
| ahbWrite | input | 1 | 1 for write |
| ahbSize | input | 3 | log2 of transfer bytes |
| ahbWdata | input | DATA_W | Write data (data phase) |
| ahbReadyIn | input | 1 | Bus-wide ready |
| ahbRdata | output | DATA_W | Read data |
| ahbReadyOut | output | 1 | This slave's ready |
| ahbResp | output | 2 | 00 OKAY, 01 ERROR |
| apbAddr | output | ADDR_W | Peripheral address |
| apbSel | output | 1 | Peripheral select |
| apbEnable | output | 1 | ACCESS-phase indicator |
| apbWrite | output | 1 | Peripheral write |
| apbWdata | output | DATA_W | Peripheral write data |
| apbStrb | output | DATA_W/8 | Byte strobes |
| apbRdata | input | DATA_W | Peripheral read data |
| apbReady | input | 1 | Peripheral completion |
| apbSlvErr | input | 1 | Peripheral error |

## Verification
Two events can land in the same cycle: the peripheral's apbReady and the watchdog's expiry on the last ACCESS cycle of its window. The bench sets the slave model to wait exactly TIMEOUT-1 cycles, so that ready arrives in that final cycle. It then expects OKAY with the correct read data and a stall of exactly TIMEOUT+2 cycles. A second run, with a slave that never answers, must instead give ERROR after TIMEOUT+3 stalled cycles.

// File: rtl/apb_bridge_pkg.sv
package apb_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAPT,
    ST_SETUP,
    ST_ACCESS,
    ST_ERR1,
    ST_ERR2
  } bridgeState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capReq;     // latch address-phase fields
    logic capWdata;   // latch write data (first data-phase cycle)
    logic loadRdata;  // latch peripheral read data on good completion
    logic clrRdata;   // zero the read data on error completion
  } dpCtl_t;

  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam logic [1:0] RESP_ERROR = 2'b01;

endpackage

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import apb_bridge_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ahbSel,
  input  logic       ahbTransSeq,
  input  logic       ahbReadyIn,
  input  logic       apbReady,
  input  logic       apbSlvErr,
  output logic       apbSel,
  output logic       apbEnable,
  output logic       ahbReadyOut,
  output logic [1:0] ahbResp,
  output dpCtl_t     dpCtl
);

  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

  bridgeState_t state, stateNxt;
  logic [CNT_W-1:0] wdogCnt, wdogNxt;
  logic accept;

  assign accept = ahbSel && ahbTransSeq && ahbReadyIn &&
                  (state == ST_IDLE || state == ST_ERR2);

  always_comb begin
    stateNxt = state;
    wdogNxt  = wdogCnt;
    dpCtl    = '0;
    unique case (state)
      ST_IDLE, ST_ERR2: begin
        if (accept) begin
          stateNxt     = ST_CAPT;
          dpCtl.capReq = 1'b1;
        end else begin
          stateNxt = ST_IDLE;
        end
      end
      ST_CAPT: begin
        dpCtl.capWdata = 1'b1;
        stateNxt       = ST_SETUP;
      end
      ST_SETUP: begin
        wdogNxt  = '0;
        stateNxt = ST_ACCESS;
      end
      ST_ACCESS: begin
        if (apbReady) begin
          if (apbSlvErr) begin
            dpCtl.clrRdata = 1'b1;
            stateNxt       = ST_ERR1;
          end else begin
            dpCtl.loadRdata = 1'b1;
            stateNxt        = ST_IDLE;
          end
        end else if (wdogCnt == CNT_LAST) begin
          dpCtl.clrRdata = 1'b1;
          stateNxt       = ST_ERR1;
        end else begin
          wdogNxt = wdogCnt + 1'b1;
        end
      end
      ST_ERR1: stateNxt = ST_ERR2;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wdogCnt <= '0;
    end else begin
      state   <= stateNxt;
      wdogCnt <= wdogNxt;
    end
  end

  assign apbSel      = (state == ST_SETUP) || (state == ST_ACCESS);
  assign apbEnable   = (state == ST_ACCESS);
  assign ahbReadyOut = (state == ST_IDLE) || (state == ST_ERR2);
  assign ahbResp     = (state == ST_ERR1 || state == ST_ERR2) ? RESP_ERROR : RESP_OKAY;

  // R4
  setup_then_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (apbSel && !apbEnable) |=> (apbSel && apbEnable));
  // R4
  enable_needs_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    apbEnable |-> apbSel);
  // R3
  stall_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    apbSel |-> !ahbReadyOut);
  // R8
  err_two_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ahbResp == RESP_ERROR && !ahbReadyOut) |=> (ahbResp == RESP_ERROR && ahbReadyOut));
  // R9
  wdog_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    apbEnable |-> (wdogCnt < CNT_W'(TIMEOUT)));
  // R9
  timeout_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (apbEnable && !apbReady && wdogCnt == CNT_LAST) |=> (!apbSel && ahbResp == RESP_ERROR));
  // R10
  ready_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (apbEnable && apbReady && !apbSlvErr) |=> (ahbReadyOut && ahbResp == RESP_OKAY));

endmodule

// File: rtl/bridge_dpath.sv
module bridge_dpath
  import apb_bridge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtl_t              dpCtl,
  input  logic [ADDR_W-1:0]   ahbAddr,
  input  logic                ahbWrite,
  input  logic [2:0]          ahbSize,
  input  logic [DATA_W-1:0]   ahbWdata,
  input  logic [DATA_W-1:0]   apbRdata,
  output logic [DATA_W-1:0]   ahbRdata,
  output logic [ADDR_W-1:0]   apbAddr,
  output logic                apbWrite,
  output logic [DATA_W-1:0]   apbWdata,
  output logic [DATA_W/8-1:0] apbStrb
);

  localparam int STRB_W = DATA_W / 8;
  localparam int LANE_W = (STRB_W > 1) ? $clog2(STRB_W) : 1;

  logic [ADDR_W-1:0] addrReg;
  logic              writeReg;
  logic [2:0]        sizeReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      writeReg <= 1'b0;
      sizeReg  <= '0;
    end else if (dpCtl.capReq) begin
      addrReg  <= ahbAddr;
      writeReg <= ahbWrite;
      sizeReg  <= ahbSize;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               wdataReg <= '0;
    else if (dpCtl.capWdata) wdataReg <= ahbWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rdataReg <= '0;
    else if (dpCtl.clrRdata)  rdataReg <= '0;
    else if (dpCtl.loadRdata) rdataReg <= writeReg ? '0 : apbRdata;
  end

  // a lane is enabled when it shares the aligned 2^size block with the address
  for (genvar g = 0; g < STRB_W; g++) begin : gLane
    assign apbStrb[g] = writeReg &&
      ((g >> sizeReg) == (int'(addrReg[LANE_W-1:0]) >> sizeReg));
  end

  assign apbAddr  = addrReg;
  assign apbWrite = writeReg;
  assign apbWdata = wdataReg;
  assign ahbRdata = rdataReg;

  // R5
  read_no_strb_chk: assert property (@(posedge clk) disable iff (!rstN)
    !apbWrite |-> (apbStrb == '0));

endmodule

// File: rtl/lite_apb_bridge.sv
module lite_apb_bridge
  import apb_bridge_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int TIMEOUT = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ahbSel,
  input  logic [ADDR_W-1:0]   ahbAddr,
  input  logic [1:0]          ahbTrans,
  input  logic                ahbWrite,
  input  logic [2:0]          ahbSize,
  input  logic [DATA_W-1:0]   ahbWdata,
  input  logic                ahbReadyIn,
  output logic [DATA_W-1:0]   ahbRdata,
  output logic                ahbReadyOut,
  output logic [1:0]          ahbResp,
  output logic [ADDR_W-1:0]   apbAddr,
  output logic                apbSel,
  output logic                apbEnable,
  output logic                apbWrite,
  output logic [DATA_W-1:0]   apbWdata,
  output logic [DATA_W/8-1:0] apbStrb,
  input  logic [DATA_W-1:0]   apbRdata,
  input  logic                apbReady,
  input  logic                apbSlvErr
);

  dpCtl_t dpCtl;

  bridge_ctrl #(.TIMEOUT(TIMEOUT)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .ahbSel      (ahbSel),
    .ahbTransSeq (ahbTrans[1]),
    .ahbReadyIn  (ahbReadyIn),
    .apbReady    (apbReady),
    .apbSlvErr   (apbSlvErr),
    .apbSel      (apbSel),
    .apbEnable   (apbEnable),
    .ahbReadyOut (ahbReadyOut),
    .ahbResp     (ahbResp),
    .dpCtl       (dpCtl)
  );

  bridge_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtl    (dpCtl),
    .ahbAddr  (ahbAddr),
    .ahbWrite (ahbWrite),
    .ahbSize  (ahbSize),
    .ahbWdata (ahbWdata),
    .apbRdata (apbRdata),
    .ahbRdata (ahbRdata),
    .apbAddr  (apbAddr),
    .apbWrite (apbWrite),
    .apbWdata (apbWdata),
    .apbStrb  (apbStrb)
  );

  // R4
  access_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (apbSel && apbEnable) |-> ($stable(apbAddr) && $stable(apbWdata) && $stable(apbWrite)));
  // R1
  idle_no_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ahbReadyOut && !(ahbSel && ahbTrans[1] && ahbReadyIn)) |=> !apbSel);

endmodule

// File: tb/lite_apb_bridge_test.sv
`timescale 1ns/1ps
module lite_apb_bridge_test;

  localparam int TMO = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ahbSel = 1'b0;
  logic [31:0] ahbAddr = '0;
  logic [1:0]  ahbTrans = 2'b00;
  logic        ahbWrite = 1'b0;
  logic [2:0]  ahbSize = 3'd2;
  logic [31:0] ahbWdata = '0;
  logic        ahbReadyIn;
  logic [31:0] ahbRdata;
  logic        ahbReadyOut;
  logic [1:0]  ahbResp;
  logic [31:0] apbAddr;
  logic        apbSel, apbEnable, apbWrite;
  logic [31:0] apbWdata;
  logic [3:0]  apbStrb;
  logic [31:0] apbRdata;
  logic        apbReady, apbSlvErr;

  logic forceLow = 1'b0;
  assign ahbReadyIn = ahbReadyOut && !forceLow;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  lite_apb_bridge #(.ADDR_W(32), .DATA_W(32), .TIMEOUT(TMO)) uut (
    .clk(clk), .rstN(rstN), .ahbSel(ahbSel), .ahbAddr(ahbAddr), .ahbTrans(ahbTrans),
    .ahbWrite(ahbWrite), .ahbSize(ahbSize), .ahbWdata(ahbWdata), .ahbReadyIn(ahbReadyIn),
    .ahbRdata(ahbRdata), .ahbReadyOut(ahbReadyOut), .ahbResp(ahbResp),
    .apbAddr(apbAddr), .apbSel(apbSel), .apbEnable(apbEnable), .apbWrite(apbWrite),
    .apbWdata(apbWdata), .apbStrb(apbStrb), .apbRdata(apbRdata), .apbReady(apbReady),
    .apbSlvErr(apbSlvErr)
  );

  // peripheral model: four words, programmable wait, error and hang
  logic [31:0] mem [4];
  int   waitCfg = 0;
  logic errFlag = 1'b0;
  logic hang = 1'b0;
  int   accessCnt = 0;
  int   selSeen = 0;
  int   setupCnt = 0;
  logic [3:0] lastStrb = '0;

  assign apbReady  = apbSel && apbEnable && !hang && (accessCnt >= waitCfg);
  assign apbSlvErr = apbReady && errFlag;
  assign apbRdata  = mem[apbAddr[3:2]];

  always @(posedge clk) begin
    if (apbSel && apbEnable && !apbReady) accessCnt <= accessCnt + 1;
    else accessCnt <= 0;
    if (apbSel) selSeen <= selSeen + 1;
    if (apbSel && !apbEnable) setupCnt <= setupCnt + 1;
    if (apbReady) begin
      lastStrb <= apbStrb;
      if (apbWrite && !errFlag)
        for (int b = 0; b < 4; b++)
          if (apbStrb[b]) mem[apbAddr[3:2]][8*b +: 8] <= apbWdata[8*b +: 8];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one transfer; returns stall length, final response, read data, error shape
  task automatic runXfer(input logic [31:0] a, input logic w, input logic [2:0] sz,
                         input logic [31:0] wd, input logic [31:0] wdLate,
                         output logic [31:0] rd, output logic [1:0] rsp,
                         output int lowCycles, output int errLow);
    @(negedge clk);
    ahbSel = 1'b1; ahbTrans = 2'b10; ahbAddr = a; ahbWrite = w; ahbSize = sz;
    @(negedge clk);
    ahbSel = 1'b0; ahbTrans = 2'b00; ahbWdata = wd;
    lowCycles = 0; errLow = 0;
    while (!ahbReadyOut && lowCycles < 200) begin
      lowCycles++;
      if (ahbResp == 2'b01) errLow++;
      @(negedge clk);
      ahbWdata = wdLate;
    end
    rsp = ahbResp;
    rd  = ahbRdata;
  endtask

  task automatic testReset;
    chk("R2 ready after reset", {31'b0, ahbReadyOut}, 32'd1);
    chk("R2 resp after reset", {30'b0, ahbResp}, 32'd0);
    chk("R2 apb idle after reset", {30'b0, apbSel, apbEnable}, 32'd0);
  endtask

  task automatic testWordRw;
    logic [31:0] rd; logic [1:0] rsp; int lc, el;
    waitCfg = 0;
    runXfer(32'h0000_0004, 1'b1, 3'd2, 32'hCAFE_1234, 32'hDEAD_DEAD, rd, rsp, lc, el);
    chk("R10 zero-wait write stall", lc, 3);
    chk("R5 word strobe", {28'b0, lastStrb}, 32'hF);
    chk("R6 write data first cycle", mem[1], 32'hCAFE_1234);
    runXfer(32'h0000_0004, 1'b0, 3'd2, 32'h0, 32'h0, rd, rsp, lc, el);
    chk("R7 read data", rd, 32'hCAFE_1234);
    chk("R7 read resp okay", {30'b0, rsp}, 32'd0);
    chk("R5 read strobe zero", {28'b0, lastStrb}, 32'h0);
  endtask

  task automatic testStrobes;
    logic [31:0] rd; logic [1:0] rsp; int lc, el;
    mem[2] = 32'h0;
    runXfer(32'h0000_0009, 1'b1, 3'd0, 32'h0000_AB00, 32'hFFFF_FFFF, rd, rsp, lc, el);
    chk("R5 byte strobe offset1", {28'b0, lastStrb}, 32'h2);
    runXfer(32'h0000_000A, 1'b1, 3'd1, 32'h5566_0000, 32'hFFFF_FFFF, rd, rsp, lc, el);
    chk("R5 half strobe offset2", {28'b0, lastStrb}, 32'hC);
    chk("R5 R6 merged word", mem[2], 32'h5566_AB00);
  endtask

  task automatic testWaits;
    logic [31:0] rd; logic [1:0] rsp; int lc, el; int s0;
    mem[3] = 32'h1357_9BDF;
    waitCfg = 3; s0 = setupCnt;
    runXfer(32'h0000_000C, 1'b0, 3'd2, 32'h0, 32'h0, rd, rsp, lc, el);
    chk("R10 three wait states stall", lc, 6);
    chk("R7 read with waits", rd, 32'h1357_9BDF);
    chk("R4 one setup cycle", setupCnt - s0, 1);
    waitCfg = 0;
  endtask

  task automatic testSlvErr;
    logic [31:0] rd; logic [1:0] rsp; int lc, el;
    errFlag = 1'b1;
    runXfer(32'h0000_0000, 1'b0, 3'd2, 32'h0, 32'h0, rd, rsp, lc, el);
    errFlag = 1'b0;
    chk("R8 error stall", lc, 4);
    chk("R8 first error cycle low", el, 1);
    chk("R8 second error cycle resp", {30'b0, rsp}, 32'd1);
  endtask

  task automatic testTimeout;
    logic [31:0] rd; logic [1:0] rsp; int lc, el;
    hang = 1'b1;
    runXfer(32'h0000_0000, 1'b1, 3'd2, 32'h1111_1111, 32'h0, rd, rsp, lc, el);
    hang = 1'b0;
    chk("R9 timeout stall", lc, TMO + 3);
    chk("R9 timeout resp", {30'b0, rsp}, 32'd1);
    chk("R9 timeout error shape", el, 1);
    chk("R9 select dropped", {31'b0, apbSel}, 32'd0);
  endtask

  task automatic testLastCycleReady;
    logic [31:0] rd; logic [1:0] rsp; int lc, el;
    mem[1] = 32'hA5A5_0F0F;
    waitCfg = TMO - 1;
    runXfer(32'h0000_0004, 1'b0, 3'd2, 32'h0, 32'h0, rd, rsp, lc, el);
    waitCfg = 0;
    chk("R10 last-cycle ready resp", {30'b0, rsp}, 32'd0);
    chk("R10 last-cycle ready data", rd, 32'hA5A5_0F0F);
    chk("R10 last-cycle ready stall", lc, TMO + 2);
  endtask

  task automatic holdIgnored(input string tag, input logic s, input logic [1:0] tr, input logic fl);
    int s0;
    @(negedge clk);
    s0 = selSeen;
    ahbSel = s; ahbTrans = tr; forceLow = fl; ahbAddr = 32'h4; ahbWrite = 1'b1;
    repeat (3) @(negedge clk);
    ahbSel = 1'b0; ahbTrans = 2'b00; forceLow = 1'b0;
    repeat (3) @(negedge clk);
    chk(tag, selSeen - s0, 0);
    chk({tag, " ready"}, {31'b0, ahbReadyOut}, 32'd1);
  endtask

  task automatic testIgnored;
    holdIgnored("R1 idle ignored", 1'b1, 2'b00, 1'b0);
    holdIgnored("R1 busy ignored", 1'b1, 2'b01, 1'b0);
    holdIgnored("R1 unselected ignored", 1'b0, 2'b10, 1'b0);
    holdIgnored("R1 ready-low ignored", 1'b1, 2'b10, 1'b1);
  endtask

  task automatic testHeld;
    logic [31:0] rd; logic [1:0] rsp; int lc, el; int s0;
    // keep requesting during the stall: only one APB access may start
    waitCfg = 2; s0 = setupCnt;
    @(negedge clk);
    ahbSel = 1'b1; ahbTrans = 2'b10; ahbAddr = 32'h0; ahbWrite = 1'b0; ahbSize = 3'd2;
    @(negedge clk);
    lc = 0;
    while (!ahbReadyOut && lc < 50) begin lc++; @(negedge clk); end
    ahbSel = 1'b0; ahbTrans = 2'b00;
    chk("R3 held stall length", lc, 5);
    chk("R3 single access during stall", setupCnt - s0, 1);
    runXfer(32'h0, 1'b0, 3'd2, 32'h0, 32'h0, rd, rsp, lc, el);
    waitCfg = 0;
  endtask

  logic finished = 1'b0;

  initial begin
    for (int i = 0; i < 4; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testWordRw();
    testStrobes();
    testWaits();
    testSlvErr();
    testTimeout();
    testLastCycleReady();
    testIgnored();
    testHeld();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule